// File: doc/BRIEF.md
# Flash Program/Erase Timing Sequencer

This block produces the timed control strobes that drive one program or erase operation on an on-chip non-volatile memory. Software loads timing values through a small parallel register port. It then issues a start command that carries an operation code and an array select. The block walks through a fixed series of phases: enable setup, store-enable setup, high-voltage pulse, hold and recovery. It drives the program/erase enable (`pe_o`) and the non-volatile store enable (`nvs_o`) for the duration of each phase, and signals the end of the operation with a one-clock `done_o`.

Every phase length is a whole number of base units. One base unit is `(div + 1)` clock cycles, where `div` is the prescaler value of the selected array. Two banks of timing registers exist, one for the main array and one for the data array. All timing values of the selected bank are captured when a command is accepted. An abort input stops an operation at any point: it drops the store enable first, then the program/erase enable.

Top module: `flash_seq_top`

## Requirements
- R1: After reset, `pe_o`, `nvs_o`, `busy_o` and `done_o` are low and every timing register of both banks holds zero.
- R2: A start accepted while idle raises `pe_o` and `busy_o` on the next clock. `pe_o` is then high with `nvs_o` low for exactly (div+1)×(setup+1) cycles.
- R3: For op code 0 (program word), `nvs_o` stays high for (div+1)×((trans+1) + 8×(prog+1) + (hold+1)) cycles.
- R4: For op code 1 (page erase) the pulse term is 4096×(page+1) base units. For op code 2 (module erase) it is 4096×(module+1) base units. The two counts come from separate registers.
- R5: The hold term is (hold+1) base units after program or page erase. After module erase it is instead 8×(mhold+1) base units, taken from its own register.
- R6: After `nvs_o` falls, `busy_o` stays high with both strobes low for (recov+1) base units. Then `done_o` is high for exactly one cycle with `busy_o` low.
- R7: Register writes use `reg_addr_i[4]` as the bank: 0 is the main array, 1 is the data array. `reg_addr_i[3:0]` selects the register: 0 div, 1 setup, 2 trans, 3 prog, 4 page, 5 module, 6 hold, 7 mhold, 8 recov. Indices 9 to 15 are ignored. `blk_i` at start picks the bank that times the operation.
- R8: `nvs_o` is never high while `pe_o` is low.
- R9: A start command received while busy is ignored, and the running sequence keeps its timing.
- R10: Register writes during an operation do not change that operation. They take effect from the next start.
- R11: `abort_i` while busy drops `nvs_o` on the next clock. If `nvs_o` was high, `pe_o` falls one clock later; otherwise it falls at once. The block returns to idle and issues no `done_o`.
- R12: A start with op code 3 is ignored, and the block stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Bank bit and register index |
| reg_wdata_i | input | REG_W | Register write data |
| start_i | input | 1 | Start command |
| op_i | input | 2 | Operation: 0 program, 1 page erase, 2 module erase |
| blk_i | input | 1 | Array select: 0 main, 1 data |
| abort_i | input | 1 | Abort the running operation |
| pe_o | output | 1 | Program/erase enable |
| nvs_o | output | 1 | Non-volatile store enable |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach is a register write or a second start that lands in the middle of a running sequence. The check must then show that neither one changed the phase lengths. The bench issues both on a chosen sample inside the setup phase. It measures the phases that follow against the values captured at start. The next operation must then reflect the new value. The module erase hold term and the long erase pulses are only visible as parts of the store-enable window, so the bench sweeps the operations against both banks and several prescaler values, and solves the window arithmetically for each combination.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  localparam int unsigned NREG = 9;
  localparam int unsigned IX_DIV   = 0;
  localparam int unsigned IX_SETUP = 1;
  localparam int unsigned IX_TRANS = 2;
  localparam int unsigned IX_PROG  = 3;
  localparam int unsigned IX_PAGE  = 4;
  localparam int unsigned IX_MOD   = 5;
  localparam int unsigned IX_HOLD  = 6;
  localparam int unsigned IX_MHOLD = 7;
  localparam int unsigned IX_RECOV = 8;

  typedef enum logic [1:0] {
    OP_PROG  = 2'd0,
    OP_PAGE  = 2'd1,
    OP_MOD   = 2'd2,
    OP_INVAL = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_TRANS, S_PULSE, S_HOLD, S_RECOV, S_DRAIN
  } phase_e;
endpackage

// File: rtl/flash_seq_regs.sv
module flash_seq_regs
  import flash_seq_pkg::*;
#(
  parameter int unsigned REG_W = 8
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                we_i,
  input  logic [4:0]                          addr_i,
  input  logic [REG_W-1:0]                    wdata_i,
  output logic [1:0][NREG-1:0][REG_W-1:0]     banks_o
);
  for (genvar b = 0; b < 2; b++) begin : g_bank
    for (genvar r = 0; r < NREG; r++) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) banks_o[b][r] <= '0;
        else if (we_i && addr_i[4] == 1'(b) && addr_i[3:0] == 4'(r))
          banks_o[b][r] <= wdata_i;
      end
    end
  end
endmodule

// File: rtl/flash_seq_prescale.sv
module flash_seq_prescale #(
  parameter int unsigned REG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [REG_W-1:0] div_i,
  output logic             tick_o
);
  logic [REG_W-1:0] pc_q;

  assign tick_o = run_i && (pc_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pc_q <= '0;
    else if (!run_i)  pc_q <= '0;
    else if (tick_o)  pc_q <= '0;
    else              pc_q <= pc_q + 1'b1;
  end

  AST_PC_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (pc_q <= div_i)); // R2
endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
  import flash_seq_pkg::*;
#(
  parameter int unsigned REG_W = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic [1:0]                    op_i,
  input  logic                          abort_i,
  input  logic [NREG-1:0][REG_W-1:0]    cfg_i,
  output logic [REG_W-1:0]              div_o,
  output logic                          run_o,
  input  logic                          tick_i,
  output logic                          pe_o,
  output logic                          nvs_o,
  output logic                          busy_o,
  output logic                          done_o
);
  localparam int unsigned UW = REG_W + 13;

  phase_e                       state_q, state_d;
  op_e                          op_q;
  logic [NREG-1:0][REG_W-1:0]   snap_q;
  logic [UW-1:0]                uc_q;
  logic [UW-1:0]                load_units;
  logic                         accept, phase_end;

  function automatic logic [UW-1:0] ext(logic [REG_W-1:0] v);
    return UW'(v) + UW'(1);
  endfunction

  assign accept    = (state_q == S_IDLE) && start_i && !abort_i && (op_i != OP_INVAL);
  assign phase_end = tick_i && (uc_q == '0);
  assign div_o     = snap_q[IX_DIV];
  assign run_o     = (state_q != S_IDLE) && (state_q != S_DRAIN);

  always_comb begin
    state_d = state_q;
    if (state_q == S_DRAIN) state_d = S_IDLE;
    else if (state_q != S_IDLE && abort_i) state_d = nvs_o ? S_DRAIN : S_IDLE;
    else if (accept) state_d = S_SETUP;
    else if (phase_end) begin
      case (state_q)
        S_SETUP: state_d = S_TRANS;
        S_TRANS: state_d = S_PULSE;
        S_PULSE: state_d = S_HOLD;
        S_HOLD:  state_d = S_RECOV;
        S_RECOV: state_d = S_IDLE;
        default: state_d = S_IDLE;
      endcase
    end
  end

  // base units of the phase being entered
  always_comb begin
    load_units = UW'(1);
    case (state_d)
      S_TRANS: load_units = ext(snap_q[IX_TRANS]);
      S_PULSE: begin
        case (op_q)
          OP_PROG: load_units = ext(snap_q[IX_PROG]) << 3;
          OP_PAGE: load_units = ext(snap_q[IX_PAGE]) << 12;
          default: load_units = ext(snap_q[IX_MOD]) << 12;
        endcase
      end
      S_HOLD:  load_units = (op_q == OP_MOD) ? (ext(snap_q[IX_MHOLD]) << 3)
                                             : ext(snap_q[IX_HOLD]);
      S_RECOV: load_units = ext(snap_q[IX_RECOV]);
      default: load_units = UW'(1);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      op_q    <= OP_PROG;
      snap_q  <= '0;
      uc_q    <= '0;
      done_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_o  <= (state_q == S_RECOV) && phase_end && !abort_i;
      if (accept) begin
        op_q   <= op_e'(op_i);
        snap_q <= cfg_i;
        uc_q   <= UW'(cfg_i[IX_SETUP]);
      end else if (phase_end && state_d != state_q) begin
        uc_q <= load_units - UW'(1);
      end else if (tick_i) begin
        uc_q <= uc_q - UW'(1);
      end
    end
  end

  always_comb begin
    pe_o   = 1'b0;
    nvs_o  = 1'b0;
    case (state_q)
      S_SETUP, S_DRAIN: pe_o = 1'b1;
      S_TRANS, S_PULSE, S_HOLD: begin pe_o = 1'b1; nvs_o = 1'b1; end
      default: ;
    endcase
    busy_o = (state_q != S_IDLE);
  end

  AST_NVS_WITHIN_PE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nvs_o |-> pe_o); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6
  AST_DONE_FROM_RECOV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_RECOV && phase_end && !abort_i) |=> (done_o && !busy_o)); // R6
  AST_SNAP_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != S_IDLE) |=> (state_q == S_IDLE || $stable(snap_q))); // R10
  AST_ABORT_DROPS_NVS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_i && busy_o) |=> (!nvs_o && !done_o)); // R11
  AST_INVAL_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && op_i == OP_INVAL) |=> !busy_o); // R12
endmodule

// File: rtl/flash_seq_top.sv
module flash_seq_top
  import flash_seq_pkg::*;
#(
  parameter int unsigned REG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [4:0]       reg_addr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  input  logic             start_i,
  input  logic [1:0]       op_i,
  input  logic             blk_i,
  input  logic             abort_i,
  output logic             pe_o,
  output logic             nvs_o,
  output logic             busy_o,
  output logic             done_o
);
  logic [1:0][NREG-1:0][REG_W-1:0] banks;
  logic [NREG-1:0][REG_W-1:0]      cfg_sel;
  logic [REG_W-1:0]                div;
  logic                            run, tick;

  assign cfg_sel = banks[blk_i];

  flash_seq_regs #(.REG_W(REG_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .banks_o(banks)
  );

  flash_seq_prescale #(.REG_W(REG_W)) u_pre (
    .clk_i, .rst_ni, .run_i(run), .div_i(div), .tick_o(tick)
  );

  flash_seq_fsm #(.REG_W(REG_W)) u_fsm (
    .clk_i, .rst_ni,
    .start_i, .op_i, .abort_i,
    .cfg_i(cfg_sel), .div_o(div), .run_o(run), .tick_i(tick),
    .pe_o, .nvs_o, .busy_o, .done_o
  );
endmodule

// File: tb/flash_seq_top_bench.sv
module flash_seq_top_bench;
  localparam int REG_W = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic reg_we_i = 1'b0;
  logic [4:0] reg_addr_i = '0;
  logic [REG_W-1:0] reg_wdata_i = '0;
  logic start_i = 1'b0;
  logic [1:0] op_i = '0;
  logic blk_i = 1'b0;
  logic abort_i = 1'b0;
  logic pe_o, nvs_o, busy_o, done_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int shadow [2][9];

  always #4 clk_i = ~clk_i;

  flash_seq_top #(.REG_W(REG_W)) u_flash_seq_top (.*);

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 190000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 190000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(int bank, int ix, int val, bit track = 1);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = 5'((bank << 4) | ix); reg_wdata_i = REG_W'(val);
    @(negedge clk_i);
    reg_we_i = 1'b0;
    if (track && ix < 9) shadow[bank][ix] = val;
  endtask

  function automatic longint exp_nvs(int op, int b);
    longint d = shadow[b][0] + 1;
    longint pulse, hold;
    pulse = (op == 0) ? 8 * (shadow[b][3] + 1) :
            (op == 1) ? 4096 * (shadow[b][4] + 1) : 4096 * (shadow[b][5] + 1);
    hold  = (op == 2) ? 8 * (shadow[b][7] + 1) : shadow[b][6] + 1;
    return d * ((shadow[b][2] + 1) + pulse + hold);
  endfunction

  // inj: 0 none, 1 start while busy, 2 register write mid-run
  task automatic run_op(int op, int b, int inj, string req);
    longint es = (shadow[b][0] + 1) * (shadow[b][1] + 1);
    longint en = exp_nvs(op, b);
    longint er = (shadow[b][0] + 1) * (shadow[b][8] + 1);
    longint cs = 0, cn = 0, cr = 0, bad = 0, n = 0;
    bit got_done = 0, first_pe;
    @(negedge clk_i);
    start_i = 1'b1; op_i = 2'(op); blk_i = 1'(b);
    @(negedge clk_i);
    start_i = 1'b0;
    first_pe = pe_o && busy_o;
    while (!got_done && n < 60000) begin
      if (done_o) begin
        got_done = 1;
        check(!busy_o, {req, " R6 busy low at done"}, busy_o, 0);
      end else begin
        if (pe_o && !nvs_o && busy_o) cs++;
        if (nvs_o) cn++;
        if (busy_o && !pe_o) cr++;
        if (nvs_o && !pe_o) bad++;
      end
      if (inj == 1 && n == 1) begin start_i = 1'b1; op_i = 2'((op + 1) % 3); blk_i = ~blk_i; end
      if (inj == 1 && n == 2) start_i = 1'b0;
      if (inj == 2 && n == 1) begin
        reg_we_i = 1'b1; reg_addr_i = 5'((b << 4) | 8); reg_wdata_i = 8'd9;
      end
      if (inj == 2 && n == 2) begin reg_we_i = 1'b0; shadow[b][8] = 9; end
      n++;
      if (!got_done) @(negedge clk_i);
    end
    check(first_pe, {req, " R2 pe one clock after start"}, first_pe, 1);
    check(cs == es, {req, " R2 setup cycles"}, cs, es);
    check(cn == en, {req, " R3/R4/R5 nvs window"}, cn, en);
    check(cr == er, {req, " R6 recovery cycles"}, cr, er);
    check(bad == 0, {req, " R8 nvs without pe"}, bad, 0);
    check(got_done, {req, " R6 done seen"}, got_done, 1);
    @(negedge clk_i);
    check(!done_o && !busy_o, {req, " R6 done single cycle"}, done_o, 0);
  endtask

  initial begin
    for (int b = 0; b < 2; b++) for (int i = 0; i < 9; i++) shadow[b][i] = 0;
    repeat (3) @(negedge clk_i);
    check(!pe_o && !nvs_o && !busy_o && !done_o, "R1 outputs low in reset",
          {pe_o, nvs_o, busy_o, done_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!pe_o && !nvs_o && !busy_o && !done_o, "R1 outputs low after reset",
          {pe_o, nvs_o, busy_o, done_o}, 0);
    // all-zero registers: minimal lengths, R1 register reset
    run_op(0, 0, 0, "R1 zero regs prog");

    // bank 0
    wr(0, 1, 2); wr(0, 2, 1); wr(0, 3, 1); wr(0, 4, 0); wr(0, 5, 0);
    wr(0, 6, 3); wr(0, 7, 1); wr(0, 8, 2);
    // bank 1 (R7 distinct values)
    wr(1, 1, 4); wr(1, 2, 0); wr(1, 3, 2); wr(1, 4, 0); wr(1, 5, 1);
    wr(1, 6, 5); wr(1, 7, 3); wr(1, 8, 1);
    // ignored indices, R7
    wr(0, 12, 200, 0); wr(1, 9, 200, 0);

    for (int dv = 0; dv < 2; dv++) begin
      wr(0, 0, dv); wr(1, 0, dv);
      for (int b = 0; b < 2; b++)
        for (int op = 0; op < 3; op++) begin
          if (!(b == 1 && op == 2 && dv == 1))
            run_op(op, b, 0, $sformatf("R7 sweep div%0d blk%0d op%0d", dv, b, op));
        end
    end
    wr(0, 0, 2);
    run_op(0, 0, 0, "R2 div2 prog");
    wr(0, 0, 0); wr(1, 0, 0);

    // R9 start while busy
    run_op(0, 0, 1, "R9 busy start");
    // R10 write mid-run then next run uses it
    run_op(0, 1, 2, "R10 mid-run write");
    run_op(0, 1, 0, "R10 new value applies");

    // R12 invalid op
    @(negedge clk_i);
    start_i = 1'b1; op_i = 2'd3; blk_i = 1'b0;
    @(negedge clk_i);
    start_i = 1'b0;
    check(!busy_o && !pe_o, "R12 op3 ignored", busy_o, 0);
    @(negedge clk_i);
    check(!busy_o && !done_o, "R12 op3 stays idle", busy_o, 0);

    // R11 abort during nvs window
    @(negedge clk_i);
    start_i = 1'b1; op_i = 2'd0; blk_i = 1'b0;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int k = 0; k < 100 && !nvs_o; k++) @(negedge clk_i);
    check(nvs_o, "R11 reached nvs window", nvs_o, 1);
    abort_i = 1'b1;
    @(negedge clk_i);
    abort_i = 1'b0;
    check(!nvs_o && pe_o && busy_o, "R11 nvs drops first", {pe_o, nvs_o}, 2);
    @(negedge clk_i);
    check(!pe_o && !busy_o, "R11 pe drops next", pe_o, 0);
    begin
      bit seen = 0;
      for (int k = 0; k < 20; k++) begin @(negedge clk_i); if (done_o) seen = 1; end
      check(!seen, "R11 no done after abort", seen, 0);
    end

    // R11 abort during setup: pe drops at once
    @(negedge clk_i);
    start_i = 1'b1; op_i = 2'd1; blk_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    check(pe_o && !nvs_o, "R11 in setup", pe_o, 1);
    abort_i = 1'b1;
    @(negedge clk_i);
    abort_i = 1'b0;
    check(!pe_o && !nvs_o && !busy_o, "R11 setup abort immediate", pe_o, 0);
    // block still usable afterwards
    run_op(1, 1, 0, "R11 run after abort");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule